// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

The block divides one input clock into two banks of registered outputs. Bank A runs at one half or one quarter of the input rate. Bank B runs at one quarter, one fifth or one sixth of it. Each bank has its own down-counter, and both counters are clocked by the same input edge and cleared by the same clear. Because of this, a rising edge that the two banks have in common always falls on the same input clock edge.

A run control is captured on the falling input edge. It freezes both outputs in whatever level they hold. A master clear passes through a short synchroniser and drives both banks low. Several copies of the block that share the master clear therefore all restart from the same edge.

The ratio selects may change at any time. A bank adopts a new ratio only when its current output period ends. Every output comes as a true/complement pair.

Top module: `ckdiv_dual`

## Requirements
- R1: With `divsel_a_i`=0, `qa_o` has a period of 2 input cycles (1 high, 1 low). With `divsel_a_i`=1, it has a period of 4 input cycles (2 high, 2 low).
- R2: For `divsel_b_i`=2'b00, `qb_o` has a period of 4 cycles (2 high, 2 low). For 2'b01, the period is 6 cycles (3 high, 3 low). For 2'b10 or 2'b11, the period is 5 cycles (2 high, then 3 low).
- R3: Both banks start their periods on the same input edge. Whenever the bank B ratio is a multiple of the bank A ratio, every rising edge of `qb_o` coincides with a rising edge of `qa_o`.
- R4: `en_ni` is sampled on the falling edge of `clk_i`. A high sample freezes `qa_o` and `qb_o` at the following rising edge and for as long as it stays high. A low sample lets both banks advance.
- R5: `mr_i` is sampled on rising edges through a two-stage synchroniser. If it is first seen high at rising edge k, both outputs are low after edge k+2 and stay low while it remains high.
- R6: If `mr_i` is first seen low at rising edge k, both `qa_o` and `qb_o` rise together at edge k+2. Both are low after edges k and k+1.
- R7: `qa_no` is always the inverse of `qa_o`, and `qb_no` is always the inverse of `qb_o`.
- R8: A change on `divsel_a_i` or `divsel_b_i` is adopted only when the affected bank starts a new period. The period already in progress completes with the old ratio.
- R9: While `rst_ni` is low, both outputs are low at once and the synchroniser holds the banks cleared. After `rst_ni` rises, the block restarts exactly as after a release of `mr_i`.
- R10: No output pulse, high or low, is shorter than one input clock period, whatever the timing of `en_ni`, `mr_i` and the selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mr_i | input | 1 | Master clear, active high, synchronised |
| en_ni | input | 1 | Run control, active low, sampled on falling edge |
| divsel_a_i | input | 1 | Bank A ratio select |
| divsel_b_i | input | 2 | Bank B ratio select |
| qa_o | output | 1 | Bank A divided clock |
| qa_no | output | 1 | Bank A divided clock, inverted |
| qb_o | output | 1 | Bank B divided clock |
| qb_no | output | 1 | Bank B divided clock, inverted |

## Verification
The hardest case to reach is a ratio select that changes in the middle of a period. It matters most when the change coincides with a freeze from the run control or a pending master clear, because a wrong reload point would only show up several cycles later as a shifted edge.

The bench drives a cycle-level model of both banks. It first runs every select combination from a clean release, measuring periods and shared edges. Directed cases then change a select one edge after a rise and freeze the outputs in the high phase. A long random phase follows in which the run control, master clear and selects all toggle at arbitrary cycles, while a monitor times every output transition.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  localparam int RW    = 3;
  localparam int NBANK = 2;

  typedef struct packed {
    logic [RW-1:0] n;
    logic [RW-1:0] hi;
  } ratio_t;

  function automatic ratio_t ratio_a(input logic sel);
    ratio_t r;
    r.n  = sel ? RW'(4) : RW'(2);
    r.hi = sel ? RW'(2) : RW'(1);
    return r;
  endfunction

  function automatic ratio_t ratio_b(input logic [1:0] sel);
    ratio_t r;
    case (sel)
      2'b00:   begin r.n = RW'(4); r.hi = RW'(2); end
      2'b01:   begin r.n = RW'(6); r.hi = RW'(3); end
      default: begin r.n = RW'(5); r.hi = RW'(2); end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ckdiv_sync.sv
module ckdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  // resets to asserted so banks stay cleared until the chain flushes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ckdiv_en_cap.sv
module ckdiv_en_cap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  output logic run_o
);
  logic run_q;

  // falling-edge capture: run changes only while the input clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= ~en_ni;
  end

  assign run_o = run_q;
endmodule

// File: rtl/ckdiv_bank.sv
module ckdiv_bank #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] n_i,
  input  logic [W-1:0] hi_i,
  output logic         q_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] n_o,
  output logic [W-1:0] hi_o
);
  logic [W-1:0] cnt_q, n_q, hi_q, cnt_dec, thr;
  logic         q_q, wrap;

  assign wrap    = (cnt_q == '0);
  assign cnt_dec = cnt_q - W'(1);
  assign thr     = n_q - hi_q;

  // down-counter: reload = period start (output rises), ratio latched only there
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      n_q   <= '0;
      hi_q  <= '0;
      q_q   <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      n_q   <= '0;
      hi_q  <= '0;
      q_q   <= 1'b0;
    end else if (run_i) begin
      if (wrap) begin
        n_q   <= n_i;
        hi_q  <= hi_i;
        cnt_q <= n_i - W'(1);
        q_q   <= 1'b1;
      end else begin
        cnt_q <= cnt_dec;
        q_q   <= (cnt_dec >= thr);
      end
    end
  end

  assign q_o   = q_q;
  assign cnt_o = cnt_q;
  assign n_o   = n_q;
  assign hi_o  = hi_q;
endmodule

// File: rtl/ckdiv_dual.sv
module ckdiv_dual
  import ckdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mr_i,
  input  logic       en_ni,
  input  logic       divsel_a_i,
  input  logic [1:0] divsel_b_i,
  output logic       qa_o,
  output logic       qa_no,
  output logic       qb_o,
  output logic       qb_no
);
  logic                       sync_clr;
  logic                       en_run;
  ratio_t [NBANK-1:0]         sel_r;
  logic   [NBANK-1:0]         q_w;
  logic   [NBANK-1:0][RW-1:0] cnt_w, n_w, hi_w;

  assign sel_r[0] = ratio_a(divsel_a_i);
  assign sel_r[1] = ratio_b(divsel_b_i);

  ckdiv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (mr_i),
    .q_o    (sync_clr)
  );

  ckdiv_en_cap u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_ni  (en_ni),
    .run_o  (en_run)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    ckdiv_bank #(.W(RW)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (sync_clr),
      .run_i  (en_run),
      .n_i    (sel_r[g].n),
      .hi_i   (sel_r[g].hi),
      .q_o    (q_w[g]),
      .cnt_o  (cnt_w[g]),
      .n_o    (n_w[g]),
      .hi_o   (hi_w[g])
    );
  end

  assign qa_o  = q_w[0];
  assign qa_no = ~q_w[0];
  assign qb_o  = q_w[1];
  assign qb_no = ~q_w[1];
endmodule

// File: rtl/ckdiv_chk.sv
module ckdiv_chk
  import ckdiv_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sync_clr_i,
  input logic          en_run_i,
  input logic          qa_i,
  input logic          qa_n_i,
  input logic          qb_i,
  input logic          qb_n_i,
  input logic [RW-1:0] a_cnt_i,
  input logic [RW-1:0] a_n_i,
  input logic [RW-1:0] a_hi_i,
  input logic [RW-1:0] b_cnt_i,
  input logic [RW-1:0] b_n_i,
  input logic [RW-1:0] b_hi_i
);
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_clr_i |=> (!qa_i && !qb_i && qa_n_i && qb_n_i));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_run_i && !sync_clr_i) |=> ($stable(qa_i) && $stable(qb_i)));

  assert_rise_a_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(qa_i) |-> (int'(a_cnt_i) + 1 == int'(a_n_i)));

  assert_fall_a_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(qa_i) && !$past(sync_clr_i)) |-> (int'(a_cnt_i) + int'(a_hi_i) + 1 == int'(a_n_i)));

  assert_rise_b_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(qb_i) |-> (int'(b_cnt_i) + 1 == int'(b_n_i)));

  assert_fall_b_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(qb_i) && !$past(sync_clr_i)) |-> (int'(b_cnt_i) + int'(b_hi_i) + 1 == int'(b_n_i)));

  assert_ratio_a_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(a_n_i) && !$past(sync_clr_i)) |-> (int'(a_cnt_i) + 1 == int'(a_n_i)));

  assert_ratio_b_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(b_n_i) && !$past(sync_clr_i)) |-> (int'(b_cnt_i) + 1 == int'(b_n_i)));
endmodule

bind ckdiv_dual ckdiv_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_clr_i (sync_clr),
  .en_run_i   (en_run),
  .qa_i       (qa_o),
  .qa_n_i     (qa_no),
  .qb_i       (qb_o),
  .qb_n_i     (qb_no),
  .a_cnt_i    (cnt_w[0]),
  .a_n_i      (n_w[0]),
  .a_hi_i     (hi_w[0]),
  .b_cnt_i    (cnt_w[1]),
  .b_n_i      (n_w[1]),
  .b_hi_i     (hi_w[1])
);

// File: tb/sim_ckdiv_dual.sv
module sim_ckdiv_dual;
  localparam int T = 8;

  logic       clk = 1'b0;
  logic       rst_ni, mr_i, en_ni, divsel_a_i;
  logic [1:0] divsel_b_i;
  logic       qa_o, qa_no, qb_o, qb_no;

  always #(T/2) clk = ~clk;

  ckdiv_dual u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mr_i(mr_i), .en_ni(en_ni),
    .divsel_a_i(divsel_a_i), .divsel_b_i(divsel_b_i),
    .qa_o(qa_o), .qa_no(qa_no), .qb_o(qb_o), .qb_no(qb_no)
  );

  // {sel_a, sel_b[1:0], period_a[2:0], period_b[2:0]}
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 2'b00, 3'd2, 3'd4}, {1'b1, 2'b00, 3'd4, 3'd4},
    {1'b0, 2'b01, 3'd2, 3'd6}, {1'b1, 2'b01, 3'd4, 3'd6},
    {1'b0, 2'b10, 3'd2, 3'd5}, {1'b1, 2'b10, 3'd4, 3'd5},
    {1'b0, 2'b11, 3'd2, 3'd5}, {1'b1, 2'b11, 3'd4, 3'd5}
  };

  int  total = 0, bad = 0;
  bit  done = 0;
  int  ph [2], mn [2], mhi [2];
  bit  st [2], mq [2];
  bit  m1, m2;
  int  edge_no = 0;
  int  last_rise [2];
  int  exp_per [2];
  bit  per_on = 0;
  bit  pa, pb;
  bit  mon_on = 0;
  time last_ta = 0, last_tb = 0;

  function automatic int per_a(input logic s);
    return s ? 4 : 2;
  endfunction
  function automatic int per_b(input logic [1:0] s);
    return (s == 2'b00) ? 4 : (s == 2'b01) ? 6 : 5;
  endfunction
  function automatic int high_of(input int n);
    return (n == 5) ? 2 : n / 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int b = 0; b < 2; b++) begin st[b] = 0; mq[b] = 0; end
  endtask

  task automatic model_edge(input bit m, input bit en_n, input bit sa, input bit [1:0] sb);
    if (m2) model_clear();
    else if (!en_n) begin
      for (int b = 0; b < 2; b++) begin
        int nn;
        nn = (b == 0) ? per_a(sa) : per_b(sb);
        if (!st[b] || ph[b] == mn[b] - 1) begin
          mn[b] = nn; mhi[b] = high_of(nn); ph[b] = 0; st[b] = 1;
        end else ph[b]++;
        mq[b] = (ph[b] < mhi[b]);
      end
    end
    m2 = m1;
    m1 = m;
  endtask

  // called at posedge+1; drives at +2, samples at next posedge+1
  task automatic tick(input bit m, input bit en_n, input bit sa, input bit [1:0] sb);
    pa = qa_o; pb = qb_o;
    #1;
    mr_i = m; en_ni = en_n; divsel_a_i = sa; divsel_b_i = sb;
    @(posedge clk); #1;
    edge_no++;
    model_edge(m, en_n, sa, sb);
    chk(qa_o == mq[0], "R1 qa vs model", int'(qa_o), int'(mq[0]));
    chk(qb_o == mq[1], "R2 qb vs model", int'(qb_o), int'(mq[1]));
    chk(qa_no == ~qa_o && qb_no == ~qb_o, "R7 complement",
        int'({qa_no, qb_no}), int'({~qa_o, ~qb_o}));
    if (per_on) begin
      if (!pa && qa_o) begin
        if (last_rise[0] >= 0)
          chk(edge_no - last_rise[0] == exp_per[0], "R1 period", edge_no - last_rise[0], exp_per[0]);
        last_rise[0] = edge_no;
      end
      if (!pb && qb_o) begin
        if (last_rise[1] >= 0)
          chk(edge_no - last_rise[1] == exp_per[1], "R2 period", edge_no - last_rise[1], exp_per[1]);
        last_rise[1] = edge_no;
        if (exp_per[1] % exp_per[0] == 0)
          chk(!pa && qa_o, "R3 shared rise", int'(qa_o), 1);
      end
    end
  endtask

  always @(qa_o) if (mon_on) begin
    if (last_ta != 0) chk(($time - last_ta) >= T, "R10 qa pulse width", int'($time - last_ta), T);
    last_ta = $time;
  end
  always @(qb_o) if (mon_on) begin
    if (last_tb != 0) chk(($time - last_tb) >= T, "R10 qb pulse width", int'($time - last_tb), T);
    last_tb = $time;
  end

  initial begin
    #(T * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; mr_i = 1; en_ni = 0; divsel_a_i = 0; divsel_b_i = 2'b00;
    m1 = 1; m2 = 1; model_clear();
    repeat (3) @(posedge clk);
    #1;
    chk(!qa_o && !qb_o && qa_no && qb_no, "R9 reset state", int'({qa_o, qb_o, qa_no, qb_no}), 3);
    #1 rst_ni = 1;

    // table walk: every ratio pair from a clean release
    for (int i = 0; i < 8; i++) begin
      bit sa; bit [1:0] sb;
      sa = VEC[i][8]; sb = VEC[i][7:6];
      exp_per[0] = int'(VEC[i][5:3]); exp_per[1] = int'(VEC[i][2:0]);
      repeat (3) tick(1, 0, sa, sb);
      last_rise[0] = -1; last_rise[1] = -1; per_on = 1;
      for (int k = 1; k <= 48; k++) begin
        tick(0, 0, sa, sb);
        if (k == 2) chk(!qa_o && !qb_o, "R6 low before start", int'({qa_o, qb_o}), 0);
        if (k == 3) chk(qa_o && qb_o, "R6 joint first rise", int'({qa_o, qb_o}), 3);
      end
      per_on = 0;
    end

    // R8: switch bank A from /4 to /2 right after a rise
    repeat (3) tick(1, 0, 1, 2'b00);
    tick(0, 0, 1, 2'b00); tick(0, 0, 1, 2'b00); tick(0, 0, 1, 2'b00);
    tick(0, 0, 0, 2'b00);
    chk(qa_o == 1, "R8 old ratio completes", int'(qa_o), 1);
    tick(0, 0, 0, 2'b10);
    tick(0, 0, 0, 2'b10);
    chk(qa_o == 0, "R8 old low phase kept", int'(qa_o), 0);
    repeat (12) tick(0, 0, 0, 2'b10);

    // R4: freeze in the high phase of both banks
    begin
      bit ha, hb;
      int guard;
      guard = 0;
      while (!(qa_o && qb_o) && guard < 40) begin tick(0, 0, 0, 2'b01); guard++; end
      ha = qa_o; hb = qb_o;
      for (int k = 0; k < 7; k++) begin
        tick(0, 1, 0, 2'b01);
        chk(qa_o == ha && qb_o == hb, "R4 outputs held", int'({qa_o, qb_o}), int'({ha, hb}));
      end
      repeat (10) tick(0, 0, 0, 2'b01);
    end

    // R5: clear latency
    tick(1, 0, 1, 2'b01); tick(1, 0, 1, 2'b01); tick(1, 0, 1, 2'b01);
    chk(!qa_o && !qb_o, "R5 cleared after sync", int'({qa_o, qb_o}), 0);
    repeat (4) tick(1, 0, 1, 2'b01);
    chk(!qa_o && !qb_o, "R5 stays low", int'({qa_o, qb_o}), 0);

    // R10: random run control, clear and selects
    mon_on = 1; last_ta = 0; last_tb = 0;
    begin
      bit sa; bit [1:0] sb;
      sa = 0; sb = 2'b00;
      for (int k = 0; k < 1500; k++) begin
        if ($urandom % 7 == 0) sa = 1'($urandom);
        if ($urandom % 5 == 0) sb = 2'($urandom);
        tick(($urandom % 25 == 0), ($urandom % 4 == 0), sa, sb);
      end
    end
    mon_on = 0;

    // R9: asynchronous reset in the middle of activity
    repeat (7) tick(0, 0, 1, 2'b10);
    #1 rst_ni = 0;
    #1;
    chk(!qa_o && !qb_o && qa_no && qb_no, "R9 async reset", int'({qa_o, qb_o, qa_no, qb_no}), 3);
    m1 = 1; m2 = 1; model_clear();
    @(posedge clk); #1;
    #1 rst_ni = 1;
    @(posedge clk); #1;
    chk(!qa_o && !qb_o, "R9 held after release", int'({qa_o, qb_o}), 0);
    m2 = m1; m1 = 0;
    tick(0, 0, 1, 2'b10);
    chk(!qa_o && !qb_o, "R9 still clear", int'({qa_o, qb_o}), 0);
    tick(0, 0, 1, 2'b10);
    chk(qa_o && qb_o, "R9 restart like release", int'({qa_o, qb_o}), 3);
    repeat (20) tick(0, 0, 1, 2'b10);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule